// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block keeps the tap position of one digitally controlled resistor ladder. A host moves the wiper over three wires: an active-low select, a step strobe that acts on its falling edge, and a direction level. The block holds a 5-bit position, with the width set by a parameter. It drives a one-hot tap-select bus that closes exactly one transfer gate of the ladder.

When select is released while the strobe is high, the block copies its position into a retained shadow register. That register stands in for a nonvolatile cell and keeps its contents through reset. A busy window of configurable length follows each save, and the block then drops into standby until it is selected again. If select is released while the strobe is low, the block is deselected and nothing is saved. On every reset the position is reloaded from the shadow register. Before the first save, that register holds a parameterised default.

All three control inputs come from an unrelated timing domain. They pass through two-flop synchronisers before any edge is detected.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tap_pos` is loaded from the shadow register (NV_DEFAULT before any save), and `busy` and `standby` clear.
- R2: A falling edge on `step_n` while `sel_n` is low and `busy` is low, with `dir_up` high, raises `tap_pos` by exactly one.
- R3: The same falling edge with `dir_up` low lowers `tap_pos` by exactly one.
- R4: `tap_pos` saturates: an up step at the top tap (2**TAP_BITS-1) and a down step at tap 0 leave it unchanged. It never wraps.
- R5: Falling edges on `step_n` while `sel_n` is high, including one seen in the same synchronised cycle as the rise of `sel_n`, leave `tap_pos` unchanged.
- R6: A rising edge on `sel_n` while `step_n` is high copies `tap_pos` into the shadow register, and the next reset restores that value.
- R7: A rising edge on `sel_n` while `step_n` is low saves nothing: `busy` stays low and the next reset restores the previously saved value.
- R8: After a save, `busy` is high for exactly STORE_CYCLES clock cycles, and strobes that arrive during that time leave `tap_pos` unchanged.
- R9: `standby` rises as the busy window ends if `sel_n` is still high, and clears once a low `sel_n` has passed the synchroniser.
- R10: `tap_sel` has exactly one bit set, at bit index `tap_pos`.
- R11: A strobe edge changes `tap_pos` on the third rising clock edge after the input changes: two synchroniser stages, then one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; recalls the saved position |
| sel_n | input | 1 | Active-low select, asynchronous to clk |
| step_n | input | 1 | Step strobe, acts on its falling edge, asynchronous to clk |
| dir_up | input | 1 | Step direction: 1 = toward the high end, 0 = toward the low end |
| tap_sel | output | 2**TAP_BITS | One-hot tap transfer-gate select |
| tap_pos | output | TAP_BITS | Current wiper position |
| busy | output | 1 | Save in progress; strobes are ignored |
| standby | output | 1 | Low-power state after a completed save |

## Verification
The deselect edge and the strobe edge can land in the same synchronised cycle. The bench provokes this by dropping `step_n` and raising `sel_n` on the same clock. The step must be dropped because the block is no longer selected, and no save may start because the strobe is low. The bench judges both outcomes at the ports: `tap_pos` and `busy` are read after the pipeline settles, and a later reset shows that the saved value is the older one. The bench also sweeps the position through every tap in both directions into saturation, and it fires a strobe inside the busy window.

// File: rtl/wpc_pkg.sv
// Shared types for the wiper position controller.
// Assumes the three control inputs are grouped and synchronised together.
package wpc_pkg;

    // Control inputs as seen by the synchroniser and edge detector
    typedef struct packed {
        logic sel_n;
        logic step_n;
        logic dir_up;
    } ctl_t;

    localparam int   CTL_W    = $bits(ctl_t);
    // Idle levels: deselected, strobe high, direction down
    localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, step_n: 1'b1, dir_up: 1'b0};

endpackage

// File: rtl/wpc_sync.sv
// Multi-stage synchroniser for a group of asynchronous levels.
// Assumes each bit is a slow level; no bus coherency is promised.
// Resets to RESET_VAL so no false edge is seen after reset.
module wpc_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RESET_VAL;
                else        stage_q[g] <= d_in;
            end
        end else begin : g_next
            // Later stages: let metastability settle
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RESET_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/wpc_step_counter.sv
// Saturating up/down tap counter.
// Assumes step_en is a single-cycle qualified step request.
// Reset reloads the counter from the retained value (recall).
module wpc_step_counter #(
    parameter int TAP_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TAP_BITS-1:0] recall_val,
    input  logic                step_en,
    input  logic                up,
    output logic [TAP_BITS-1:0] pos
);

    localparam logic [TAP_BITS-1:0] TOP = {TAP_BITS{1'b1}};

    logic [TAP_BITS-1:0] pos_q, pos_d;

    // Next position: one step in the requested direction, held at the ends
    always_comb begin
        pos_d = pos_q;
        if (step_en) begin
            if (up && pos_q != TOP)       pos_d = pos_q + 1'b1;
            else if (!up && pos_q != '0)  pos_d = pos_q - 1'b1;
        end
    end

    // Position register with recall on reset
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= recall_val;
        else        pos_q <= pos_d;
    end

    assign pos = pos_q;

endmodule

// File: rtl/wpc_nv_store.sv
// Retained shadow register with save timing and standby flag.
// The shadow register is not touched by reset: it models a cell that
// keeps its content across power cycles, starting from NV_DEFAULT.
// Assumes store_req is a single-cycle pulse.
module wpc_nv_store #(
    parameter int TAP_BITS     = 5,
    parameter int STORE_CYCLES = 64,
    parameter int NV_DEFAULT   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                store_req,
    input  logic                selected,
    input  logic [TAP_BITS-1:0] pos,
    output logic [TAP_BITS-1:0] nv_val,
    output logic                busy,
    output logic                standby
);

    localparam int BW = $clog2(STORE_CYCLES + 1);

    logic [TAP_BITS-1:0] nv_q = TAP_BITS'(NV_DEFAULT);
    logic [BW-1:0]       busy_cnt_q;
    logic                standby_q;
    logic                save_done;

    // Shadow register: captures the position on each save request
    always_ff @(posedge clk) begin
        if (store_req) nv_q <= pos;
    end

    // Busy timer: counts down the save window
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_cnt_q <= '0;
        else if (store_req)        busy_cnt_q <= BW'(STORE_CYCLES);
        else if (busy_cnt_q != '0) busy_cnt_q <= busy_cnt_q - 1'b1;
    end

    assign save_done = (busy_cnt_q == BW'(1)) && !store_req;

    // Standby: entered as a save finishes while deselected, left on select
    always_ff @(posedge clk) begin
        if (!rst_n)         standby_q <= 1'b0;
        else if (selected)  standby_q <= 1'b0;
        else if (save_done) standby_q <= 1'b1;
    end

    assign nv_val  = nv_q;
    assign busy    = (busy_cnt_q != '0);
    assign standby = standby_q;

endmodule

// File: rtl/wpc_tap_decode.sv
// Binary to one-hot tap decoder, one comparator per tap.
// Assumes every code of pos is a valid tap.
module wpc_tap_decode #(
    parameter int TAP_BITS = 5
) (
    input  logic [TAP_BITS-1:0]      pos,
    output logic [(1<<TAP_BITS)-1:0] tap_sel
);

    for (genvar t = 0; t < (1 << TAP_BITS); t++) begin : g_tap
        assign tap_sel[t] = (pos == TAP_BITS'(t));
    end

endmodule

// File: rtl/wiper_pos_ctrl.sv
// Top of the wiper position controller.
// Synchronises the select/strobe/direction inputs, detects edges,
// steps a saturating counter, saves it on a qualified deselect and
// decodes it to a one-hot tap select. Assumes inputs are asynchronous
// levels held for at least SYNC_STAGES+1 clock cycles.
module wiper_pos_ctrl
    import wpc_pkg::*;
#(
    parameter int TAP_BITS     = 5,
    parameter int STORE_CYCLES = 64,
    parameter int NV_DEFAULT   = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_n,
    input  logic                      step_n,
    input  logic                      dir_up,
    output logic [(1<<TAP_BITS)-1:0]  tap_sel,
    output logic [TAP_BITS-1:0]       tap_pos,
    output logic                      busy,
    output logic                      standby
);

    ctl_t                raw_ctl, sync_ctl, prev_ctl;
    logic [CTL_W-1:0]    sync_vec;
    logic                step_fall, sel_rise, selected;
    logic                step_en, store_req;
    logic [TAP_BITS-1:0] nv_val;

    assign raw_ctl = '{sel_n: sel_n, step_n: step_n, dir_up: dir_up};

    wpc_sync #(
        .WIDTH     (CTL_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (CTL_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_ctl),
        .d_out (sync_vec)
    );

    assign sync_ctl = ctl_t'(sync_vec);

    // Edge-detect stage: previous synchronised levels
    always_ff @(posedge clk) begin
        if (!rst_n) prev_ctl <= CTL_IDLE;
        else        prev_ctl <= sync_ctl;
    end

    assign step_fall = prev_ctl.step_n & ~sync_ctl.step_n;
    assign sel_rise  = ~prev_ctl.sel_n & sync_ctl.sel_n;
    assign selected  = ~sync_ctl.sel_n;
    assign step_en   = step_fall & selected & ~busy;
    assign store_req = sel_rise & sync_ctl.step_n;

    wpc_step_counter #(
        .TAP_BITS (TAP_BITS)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .recall_val (nv_val),
        .step_en    (step_en),
        .up         (sync_ctl.dir_up),
        .pos        (tap_pos)
    );

    wpc_nv_store #(
        .TAP_BITS     (TAP_BITS),
        .STORE_CYCLES (STORE_CYCLES),
        .NV_DEFAULT   (NV_DEFAULT)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_req (store_req),
        .selected  (selected),
        .pos       (tap_pos),
        .nv_val    (nv_val),
        .busy      (busy),
        .standby   (standby)
    );

    wpc_tap_decode #(
        .TAP_BITS (TAP_BITS)
    ) u_decode (
        .pos     (tap_pos),
        .tap_sel (tap_sel)
    );

endmodule

// File: rtl/wpc_checker.sv
// Property checker for wiper_pos_ctrl, attached by bind.
// Observes only the top-level ports.
module wpc_checker #(
    parameter int TAP_BITS = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [(1<<TAP_BITS)-1:0] tap_sel,
    input logic [TAP_BITS-1:0]      tap_pos,
    input logic                     busy,
    input logic                     standby
);

    // R10: exactly one tap closed
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel) == 1);

    // R10: the closed tap is the one the position names
    p_tap_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tap_sel[tap_pos] == 1'b1);

    // R2 R3 R4: any change is a single step, with no wrap between the ends
    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tap_pos) |->
            ((int'(tap_pos) - int'($past(tap_pos)) == 1) ||
             (int'($past(tap_pos)) - int'(tap_pos) == 1)));

    // R8: no movement while a save is in progress
    p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tap_pos));

    // R9: standby is only reached after the save window closes
    p_standby_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !busy);

endmodule

bind wiper_pos_ctrl wpc_checker #(.TAP_BITS(TAP_BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tap_sel (tap_sel),
    .tap_pos (tap_pos),
    .busy    (busy),
    .standby (standby)
);

// File: tb/wiper_pos_ctrl_tb_top.sv
// Self-checking bench: sweeps every tap both ways into saturation and
// exercises save, no-save, busy, standby and the coincident-edge case.
module wiper_pos_ctrl_tb_top;

    localparam int TAP_BITS = 5;
    localparam int STORE_CY = 12;
    localparam int NV_DEF   = 9;
    localparam int TOP      = (1 << TAP_BITS) - 1;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic                     sel_n, step_n, dir_up;
    logic [(1<<TAP_BITS)-1:0] tap_sel;
    logic [TAP_BITS-1:0]      tap_pos;
    logic                     busy, standby;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  exp_pos;
    int  exp_nv;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    wiper_pos_ctrl #(
        .TAP_BITS     (TAP_BITS),
        .STORE_CYCLES (STORE_CY),
        .NV_DEFAULT   (NV_DEF),
        .SYNC_STAGES  (2)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .step_n  (step_n),
        .dir_up  (dir_up),
        .tap_sel (tap_sel),
        .tap_pos (tap_pos),
        .busy    (busy),
        .standby (standby)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One full strobe pulse in the given direction
    task automatic pulse(input bit up);
        dir_up = up;
        tick(3);
        step_n = 1'b0;
        tick(4);
        step_n = 1'b1;
        tick(4);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        rst_n  = 1'b0;
        sel_n  = 1'b1;
        step_n = 1'b1;
        dir_up = 1'b0;
        exp_nv = NV_DEF;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: first power-up recall and idle flags
        check("R1 tap_pos", int'(tap_pos), NV_DEF);
        check("R1 busy", int'(busy), 0);
        check("R1 standby", int'(standby), 0);
        check("R10 tap_sel", int'(tap_sel == (32'd1 << NV_DEF)), 1);
        exp_pos = NV_DEF;

        sel_n = 1'b0;
        tick(4);

        // R11: latency through synchroniser and edge detect
        dir_up = 1'b1;
        tick(3);
        step_n = 1'b0;
        tick(2);
        check("R11 before third edge", int'(tap_pos), exp_pos);
        tick(1);
        exp_pos++;
        check("R11 on third edge", int'(tap_pos), exp_pos);
        step_n = 1'b1;
        tick(4);

        // R2 R4: up sweep into saturation
        for (int i = 0; i < 26; i++) begin
            pulse(1'b1);
            exp_pos = (exp_pos < TOP) ? exp_pos + 1 : TOP;
            check("R2/R4 up sweep", int'(tap_pos), exp_pos);
            check("R10 one-hot up", int'(tap_sel == (32'd1 << exp_pos)), 1);
        end

        // R3 R4: down sweep into saturation
        for (int i = 0; i < 36; i++) begin
            pulse(1'b0);
            exp_pos = (exp_pos > 0) ? exp_pos - 1 : 0;
            check("R3/R4 down sweep", int'(tap_pos), exp_pos);
            check("R10 one-hot down", int'(tap_sel == (32'd1 << exp_pos)), 1);
        end

        for (int i = 0; i < 7; i++) pulse(1'b1);
        exp_pos = 7;
        check("R2 climb", int'(tap_pos), exp_pos);

        // R6 R8 R9: save with strobe high, measure busy window
        begin
            int busy_cy = 0;
            sel_n = 1'b1;
            for (int i = 0; i < 40; i++) begin
                tick(1);
                if (busy) busy_cy++;
            end
            exp_nv = exp_pos;
            check("R8 busy length", busy_cy, STORE_CY);
            check("R9 standby after save", int'(standby), 1);
        end
        sel_n = 1'b0;
        tick(4);
        check("R9 standby cleared", int'(standby), 0);

        // R5: strobes while deselected (deselect with strobe high saves again)
        sel_n = 1'b1;
        tick(20);
        for (int i = 0; i < 3; i++) pulse(1'b1);
        check("R5 deselected ignore", int'(tap_pos), exp_pos);

        // R8: strobe inside the busy window is dropped
        sel_n = 1'b0;
        tick(4);
        pulse(1'b1);
        exp_pos++;
        check("R2 step before save", int'(tap_pos), exp_pos);
        sel_n = 1'b1;
        exp_nv = exp_pos;
        tick(4);
        sel_n = 1'b0;
        tick(3);
        step_n = 1'b0;
        tick(3);
        step_n = 1'b1;
        tick(20);
        check("R8 busy ignore", int'(tap_pos), exp_pos);

        // R6: reset restores the saved value
        pulse(1'b1);
        pulse(1'b1);
        do_reset();
        exp_pos = exp_nv;
        check("R6 recall", int'(tap_pos), exp_nv);

        // R7: deselect with strobe low does not save
        tick(4);
        pulse(1'b1);
        pulse(1'b1);
        step_n = 1'b0;
        tick(4);
        exp_pos = exp_nv + 3;
        sel_n = 1'b1;
        tick(4);
        check("R7 no busy", int'(busy), 0);
        step_n = 1'b1;
        tick(20);
        check("R7 position held", int'(tap_pos), exp_pos);
        check("R7 no standby", int'(standby), 0);
        do_reset();
        check("R7 old value recalled", int'(tap_pos), exp_nv);
        exp_pos = exp_nv;

        // R5 R7: strobe fall and deselect in the same cycle
        sel_n = 1'b0;
        tick(4);
        pulse(1'b0);
        exp_pos--;
        check("R3 step before coincidence", int'(tap_pos), exp_pos);
        sel_n  = 1'b1;
        step_n = 1'b0;
        tick(6);
        check("R5 coincident step dropped", int'(tap_pos), exp_pos);
        check("R7 coincident no save", int'(busy), 0);
        step_n = 1'b1;
        tick(4);
        do_reset();
        check("R7 coincident recall", int'(tap_pos), exp_nv);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule